// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Timer

This block is a 16-bit up-counting timer that drives a single pulse-width-modulated output from two compare values. When the counter reaches the first compare value, the pulse begins: the output moves to its active level. When the counter reaches the second compare value, the pulse ends and the counter restarts from zero. The second value therefore sets the period and the first sets where the pulse starts. An invert bit swaps the active and inactive levels. A power-of-two prescaler, selected by a 4-bit field, sets the count rate.

Software reaches the block through a small word-wide register port. There are seven registers: the two compare values, the counter, a control word, the prescaler select, an interrupt mask and the interrupt flags. Optional shadow buffers let software stage new compare values at any time. The buffers are copied into use only when a second-compare match restarts the counter, so a change of period or duty never produces a truncated or doubled pulse. Each compare match sets a flag. The interrupt request is raised while any flag is set together with its mask bit.

Top module: `pwm_dual_cmp_timer`

## Requirements
- R1: After reset every register reads 0x0000, `pwm_out` is 0 and `irq` is 0.
- R2: Register offsets are 0 first compare, 1 second compare, 2 counter, 3 control, 4 prescaler select (bits 3:0), 5 interrupt mask, 6 interrupt flags. Control bit 0 is run, bit 1 is invert and bit 2 is buffer enable. In the mask and flag registers, bit 0 belongs to the first compare and bit 1 to the second. All other bits, and offset 7, read as 0.
- R3: With run set and prescaler select N, the counter advances by one every 2^N clock cycles, counted from the edge that sets run. With run clear, the counter holds its value.
- R4: At a count step where the counter equals the first compare value, flag bit 0 is set and the output takes its active level. The counter keeps stepping.
- R5: At a count step where the counter equals the second compare value, flag bit 1 is set, the output takes its inactive level and the counter becomes 0.
- R6: The active level is 1 when invert is 0 and 0 when invert is 1. While run is clear, the output shows the inactive level.
- R7: With buffer enable clear, a write to either compare offset changes the compare value in use at once, and a read returns that value.
- R8: With buffer enable set, compare writes and reads reach shadow registers. Both shadows are copied into use only at a second-compare match.
- R9: A write to the counter offset loads the counter and takes priority over a count step in the same cycle.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. `irq` is the OR over both bits of flag AND mask.
- R11: When the counter passes 0xFFFF without a second-compare match, it wraps to 0x0000 and the shadows are not copied.
- R12: When both compare values are equal, a match sets both flags and the output stays at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, several properties of the counter and the compare logic. The counter must hold between count steps and advance by exactly one on a step with no match, wrapping included. A second-compare match must zero the counter and set its flag, and a first-compare match must drive the active level. Both shadows must be copied exactly at a buffered restart and stay out of use otherwise. A write of 1 to a flag bit must clear it. Some behaviour only the directed scenarios can show. These are the exact step spacing for each prescaler select, the register map and its reserved bits, and the pulse shape over several periods in both polarities. The scenarios also cover mid-period compare writes with the buffer on and off, the wrap without a buffer load, and the equal-compare case.

// File: rtl/pwm_dual_cmp_timer.sv
`timescale 1ns/10ps
module pwm_dual_cmp_timer #(
  parameter int CNT_W    = 16,
  parameter int DIVSEL_W = 4,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              pwm_out,
  output logic              irq
);
  localparam int PRE_W = (1 << DIVSEL_W) - 1;
  localparam logic [ADDR_W-1:0] OFS_CMPA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CMPB = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_DIV  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_MSK  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFS_FLG  = ADDR_W'(6);

  logic [CNT_W-1:0]    cmp_a, cmp_b, buf_a, buf_b, cnt;
  logic                run_q, inv_q, bufen_q, lvl_q;
  logic [DIVSEL_W-1:0] div_sel;
  logic [1:0]          irq_en, irq_flag;
  logic [PRE_W-1:0]    presc, pre_mask;

  wire wr_a   = bus_wr && bus_addr == OFS_CMPA;
  wire wr_b   = bus_wr && bus_addr == OFS_CMPB;
  wire wr_cnt = bus_wr && bus_addr == OFS_CNT;
  wire wr_ctl = bus_wr && bus_addr == OFS_CTL;
  wire wr_div = bus_wr && bus_addr == OFS_DIV;
  wire wr_msk = bus_wr && bus_addr == OFS_MSK;
  wire wr_flg = bus_wr && bus_addr == OFS_FLG;

  assign pre_mask = ~({PRE_W{1'b1}} << div_sel);
  wire tick  = run_q && ((presc & pre_mask) == pre_mask);
  wire hit_a = tick && (cnt == cmp_a);
  wire hit_b = tick && (cnt == cmp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      inv_q   <= 1'b0;
      bufen_q <= 1'b0;
      div_sel <= '0;
      irq_en  <= '0;
    end else begin
      if (wr_ctl) begin
        run_q   <= bus_wdata[0];
        inv_q   <= bus_wdata[1];
        bufen_q <= bus_wdata[2];
      end
      if (wr_div) div_sel <= bus_wdata[DIVSEL_W-1:0];
      if (wr_msk) irq_en <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      presc <= '0;
    else if (!run_q) presc <= '0;
    else             presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= bus_wdata;
    else if (hit_b)  cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
      buf_a <= '0;
      buf_b <= '0;
    end else begin
      if (wr_a && bufen_q) buf_a <= bus_wdata;
      if (wr_b && bufen_q) buf_b <= bus_wdata;
      if (wr_a && !bufen_q)      cmp_a <= bus_wdata;
      else if (hit_b && bufen_q) cmp_a <= buf_a;
      if (wr_b && !bufen_q)      cmp_b <= bus_wdata;
      else if (hit_b && bufen_q) cmp_b <= buf_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= 1'b0;
    else if (!run_q) lvl_q <= 1'b0;
    else if (hit_b)  lvl_q <= 1'b0;
    else if (hit_a)  lvl_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flag <= '0;
    else irq_flag <= (irq_flag & ~(wr_flg ? bus_wdata[1:0] : 2'b00)) | {hit_b, hit_a};
  end

  assign pwm_out = run_q ? (lvl_q ^ inv_q) : inv_q;
  assign irq     = |(irq_flag & irq_en);

  always_comb begin
    case (bus_addr)
      OFS_CMPA: bus_rdata = bufen_q ? buf_a : cmp_a;
      OFS_CMPB: bus_rdata = bufen_q ? buf_b : cmp_b;
      OFS_CNT:  bus_rdata = cnt;
      OFS_CTL:  bus_rdata = {{(CNT_W-3){1'b0}}, bufen_q, inv_q, run_q};
      OFS_DIV:  bus_rdata = {{(CNT_W-DIVSEL_W){1'b0}}, div_sel};
      OFS_MSK:  bus_rdata = {{(CNT_W-2){1'b0}}, irq_en};
      OFS_FLG:  bus_rdata = {{(CNT_W-2){1'b0}}, irq_flag};
      default:  bus_rdata = '0;
    endcase
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit_b && !wr_cnt) |=> cnt == $past(cnt) + CNT_W'(1)); // R11
  AST_B_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && !wr_cnt) |=> (cnt == '0) && irq_flag[1]); // R5
  AST_A_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !hit_b && !wr_ctl) |=> irq_flag[0] && (pwm_out == ~inv_q)); // R4
  AST_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && bufen_q) |=> (cmp_a == $past(buf_a)) && (cmp_b == $past(buf_b))); // R8
  AST_SHADOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bufen_q && !hit_b) |=> $stable(cmp_a) && $stable(cmp_b)); // R8
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && bus_wdata[0] && !hit_a) |=> !irq_flag[0]); // R10
endmodule

// File: tb/pwm_dual_cmp_timer_tb.sv
`timescale 1ns/10ps
module pwm_dual_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_out, irq;
  logic [15:0] rv;
  int checks = 0, fails = 0, cyc = 0;

  pwm_dual_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a);
    bus_addr = 3'(a); #0.2; rv = bus_rdata;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) begin rd(a); chk("R1 reg", rv, 0); end
    chk("R1 pwm", pwm_out, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_regmap();
    wr(0, 16'h1234); wr(1, 16'hABCD);
    rd(0); chk("R2 cmpA", rv, 16'h1234);
    rd(1); chk("R2 cmpB", rv, 16'hABCD);
    wr(4, 16'hFFFF); rd(4); chk("R2 div", rv, 16'h000F);
    wr(5, 16'hFFFF); rd(5); chk("R2 mask", rv, 16'h0003);
    chk("R2 irq no flags", irq, 0);
    wr(3, 16'hFFF6); rd(3); chk("R2 ctl", rv, 16'h0006);
    chk("R6 stopped inverted", pwm_out, 1);
    wr(3, 0); wr(4, 0); wr(5, 0);
    chk("R6 stopped plain", pwm_out, 0);
  endtask

  task automatic t_pwm();
    int c;
    wr(0, 3); wr(1, 7); wr(5, 3); wr(3, 1);
    for (int k = 1; k <= 20; k++) begin
      step();
      c = k % 8;
      rd(2); chk("R5 count", rv, c);
      chk("R4 pwm", pwm_out, (c > 3 && c <= 7) ? 1 : 0);
      if (k == 4) begin rd(6); chk("R4 flagA only", rv, 1); end
    end
    rd(6); chk("R5 flags", rv, 3);
    chk("R10 irq", irq, 1);
    wr(3, 0);
    for (int k = 0; k < 5; k++) step();
    rd(2); chk("R3 hold stopped", rv, 5);
    chk("R6 stopped", pwm_out, 0);
  endtask

  task automatic t_flags();
    wr(5, 0); chk("R10 masked", irq, 0);
    wr(5, 2); chk("R10 maskB", irq, 1);
    wr(6, 0); rd(6); chk("R10 write0", rv, 3);
    wr(6, 2); rd(6); chk("R10 clrB", rv, 1);
    chk("R10 irq after clrB", irq, 0);
    wr(5, 1); chk("R10 maskA", irq, 1);
    wr(6, 1); rd(6); chk("R10 clrA", rv, 0);
    chk("R10 irq clear", irq, 0);
  endtask

  task automatic t_presc();
    wr(2, 0); wr(1, 16'hFFFF); wr(0, 16'hFFFF); wr(4, 2); wr(3, 1);
    for (int k = 1; k <= 12; k++) begin
      step(); rd(2); chk("R3 div4", rv, k / 4);
    end
    wr(3, 0); wr(4, 5); wr(2, 0); wr(3, 1);
    for (int k = 1; k <= 64; k++) begin
      step();
      if (k == 31 || k == 32 || k == 64) begin rd(2); chk("R3 div32", rv, k / 32); end
    end
    wr(3, 0); wr(4, 0);
  endtask

  task automatic t_load();
    wr(2, 16'h1234); rd(2); chk("R9 load stopped", rv, 16'h1234);
    wr(3, 1); step(); step();
    rd(2); chk("R9 run", rv, 16'h1236);
    wr(2, 100); rd(2); chk("R9 load priority", rv, 100);
    step(); rd(2); chk("R9 continue", rv, 101);
    wr(3, 0);
  endtask

  task automatic t_invert();
    int c;
    wr(2, 0); wr(0, 2); wr(1, 5); wr(3, 3);
    for (int k = 1; k <= 15; k++) begin
      step(); c = k % 6;
      chk("R6 inverted pwm", pwm_out, (c > 2 && c <= 5) ? 0 : 1);
    end
    wr(3, 2); chk("R6 stop inactive", pwm_out, 1);
    step(); chk("R6 stop hold", pwm_out, 1);
    wr(3, 0);
  endtask

  task automatic t_unbuf();
    wr(2, 0); wr(1, 10); wr(3, 1);
    step(); step(); step();
    rd(2); chk("R7 pre", rv, 3);
    wr(1, 4); rd(2); chk("R7 step", rv, 4);
    rd(1); chk("R7 readback", rv, 4);
    step(); rd(2); chk("R7 immediate B", rv, 0);
    wr(3, 0);
  endtask

  task automatic t_buf();
    int c;
    wr(2, 0); wr(0, 2); wr(1, 10); wr(3, 4);
    wr(0, 1); wr(1, 4);
    rd(0); chk("R8 shadow A read", rv, 1);
    rd(1); chk("R8 shadow B read", rv, 4);
    wr(3, 5);
    for (int k = 1; k <= 16; k++) begin
      step();
      if (k <= 10) c = k; else c = (k - 11) % 5;
      rd(2); chk("R8 count", rv, c);
      if (k <= 10) chk("R8 old duty", pwm_out, (c > 2) ? 1 : 0);
      else chk("R8 new duty", pwm_out, (c > 1 && c <= 4) ? 1 : 0);
    end
    wr(3, 0);
  endtask

  task automatic t_wrap();
    int c;
    wr(1, 5); wr(0, 1); wr(2, 16'hFFFD);
    wr(3, 4); wr(1, 2); wr(0, 1);
    wr(3, 5);
    for (int k = 1; k <= 12; k++) begin
      step();
      if (k <= 2) c = 16'hFFFD + k;
      else if (k <= 8) c = k - 3;
      else c = (k - 9) % 3;
      rd(2); chk("R11 wrap count", rv, c);
    end
    wr(3, 0);
  endtask

  task automatic t_equal();
    wr(6, 3); wr(0, 2); wr(1, 2); wr(2, 0); wr(3, 1);
    for (int k = 1; k <= 9; k++) begin
      step();
      rd(2); chk("R12 count", rv, k % 3);
      chk("R12 pwm", pwm_out, 0);
    end
    rd(6); chk("R12 flags", rv, 3);
    wr(3, 0);
  endtask

  initial begin
    #12 rst_n = 1'b1;
    step();
    t_reset();
    t_regmap();
    t_pwm();
    t_flags();
    t_presc();
    t_load();
    t_invert();
    t_unbuf();
    t_buf();
    t_wrap();
    t_equal();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule